// File: doc/BRIEF.md
# Indirect Packet Memory Access Port

This block lets a host reach packet storage through two registers. The host first writes a pointer word, which holds a byte offset inside a 2 KiB packet window and three mode flags. It then reads or writes a data register, one byte or one 16-bit word at a time. One mode flag picks the packet: either the packet at the head of the receive queue or the packet named on the transmit packet-number input. Both packet numbers arrive as plain inputs. The block joins the packet number and the offset into a word address for a synchronous 16-bit RAM with byte enables. It can also step the offset forward after each data access.

When the read-intent flag is set, the block fetches the addressed word ahead of time. It does this after every pointer write and after every accepted data access, so a read always returns the word at the current offset. A small state machine runs this fetch. In ST_IDLE the block accepts data accesses. ST_IDLE goes to ST_FETCH on a pointer write with read intent, or on an accepted access while read intent is set; otherwise it stays in ST_IDLE. ST_FETCH issues the RAM read and moves to ST_CAPTURE. ST_CAPTURE latches the RAM word and returns to ST_IDLE. A pointer write in any state sends the machine to ST_FETCH if its read-intent bit is set, and to ST_IDLE if it is clear. `busy` is high while the machine is in ST_FETCH or ST_CAPTURE.

Top module: `pkt_access_port`

## Requirements
- R1: Reset clears the offset and all mode flags. After reset, `busy` is 0, `dat_rdata` is 0 and no RAM access is issued.
- R2: The pointer word written on `ptr_wdata` is decoded as follows: bits 10:0 are the byte offset, bit 13 is read intent, bit 14 is auto-increment and bit 15 is receive select. If `ptr_wr` and a data access occur in the same cycle, the pointer write wins and the data access is dropped.
- R3: The packet number is `rx_head_pkt` when receive select is 1 and `tx_pkt_num` when it is 0. The RAM word address is {packet, offset[10:1]}, so the byte address is packet*2048 + offset.
- R4: A byte write uses the lane given by offset bit 0. Lane 0 is `ram_be`=01 with the byte on `ram_wdata[7:0]`. Lane 1 is `ram_be`=10 with the byte on `ram_wdata[15:8]`. The byte is taken from `dat_wdata[7:0]`.
- R5: A word access (`dat_word`=1) ignores offset bit 0, so it is aligned down. A word write drives `ram_be`=11.
- R6: With auto-increment set, an accepted access advances the offset. A byte access adds 1 to the offset. A word access sets the offset to the aligned offset plus 2. The offset wraps modulo 2048.
- R7: With auto-increment clear, accesses leave the offset unchanged.
- R8: A pointer write with read intent set starts a prefetch. `busy` stays high for exactly two cycles, after which a read returns the word at the new offset.
- R9: A word read returns the fetched word. A byte read returns the lane selected by offset bit 0, zero-extended to 16 bits.
- R10: With read intent clear, a data read returns the last fetched value and does not advance the offset.
- R11: With read intent set, every accepted read or write triggers a new prefetch at the updated offset.
- R12: Data accesses presented while `busy` is high are ignored. They cause no RAM write and no offset change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ptr_wr | input | 1 | Pointer register write strobe |
| ptr_wdata | input | 16 | Pointer word: offset and mode flags |
| dat_rd | input | 1 | Data register read strobe |
| dat_wr | input | 1 | Data register write strobe |
| dat_word | input | 1 | 1 selects a 16-bit access, 0 selects a byte access |
| dat_wdata | input | 16 | Write data (byte writes use bits 7:0) |
| dat_rdata | output | 16 | Read data, valid while `busy` is low |
| busy | output | 1 | Prefetch in progress |
| rx_head_pkt | input | PKT_NUM_W | Packet at the head of the receive queue |
| tx_pkt_num | input | PKT_NUM_W | Packet named by the packet-number register |
| ram_en | output | 1 | RAM access enable |
| ram_we | output | 1 | RAM write enable |
| ram_be | output | 2 | RAM byte enables |
| ram_addr | output | PKT_NUM_W+10 | RAM word address |
| ram_wdata | output | 16 | RAM write data |
| ram_rdata | input | 16 | RAM read data, one cycle after the read |

## Verification
The hardest situation to reach is a data access that lands inside the two-cycle prefetch window. A host that waits on `busy` never produces it. The bench creates it on purpose by issuing a write on the very next cycle after a read-intent pointer write. It then confirms that no write strobe reached the RAM and that a later read still returns the unmodified word at the original offset. A second hard case is a read made with read intent cleared after a fetch has already happened. The bench checks it through the address of the following write, which shows whether the offset moved.

// File: rtl/pap_pkg.sv
package pap_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_FETCH   = 2'd1,
        ST_CAPTURE = 2'd2
    } pap_state_e;

    localparam int PTR_RD_BIT   = 13;
    localparam int PTR_INC_BIT  = 14;
    localparam int PTR_RXS_BIT  = 15;
    localparam int DATA_W       = 16;
endpackage

// File: rtl/pap_pointer.sv
module pap_pointer #(
    parameter int OFF_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld,
    input  logic [15:0]      ld_val,
    input  logic             adv,
    input  logic             adv_word,
    output logic [OFF_W-1:0] off,
    output logic             rd_intent,
    output logic             auto_inc,
    output logic             rx_sel
);
    import pap_pkg::*;

    localparam logic [OFF_W-1:0] STEP_BYTE = OFF_W'(1);
    localparam logic [OFF_W-1:0] STEP_WORD = OFF_W'(2);

    logic unused_ptr_bits;
    assign unused_ptr_bits = ^ld_val[PTR_RD_BIT-1:OFF_W];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off       <= '0;
            rd_intent <= 1'b0;
            auto_inc  <= 1'b0;
            rx_sel    <= 1'b0;
        end else if (ld) begin
            off       <= ld_val[OFF_W-1:0];
            rd_intent <= ld_val[PTR_RD_BIT];
            auto_inc  <= ld_val[PTR_INC_BIT];
            rx_sel    <= ld_val[PTR_RXS_BIT];
        end else if (adv) begin
            if (adv_word)
                off <= {off[OFF_W-1:1], 1'b0} + STEP_WORD;
            else
                off <= off + STEP_BYTE;
        end
    end

    AST_HOLD_WITHOUT_ADV: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && !adv) |=> $stable(off)); // R7
endmodule

// File: rtl/pap_addr.sv
module pap_addr #(
    parameter int PKT_NUM_W = 4,
    parameter int OFF_W     = 11,
    localparam int RAM_AW   = PKT_NUM_W + OFF_W - 1
) (
    input  logic                 rx_sel,
    input  logic [PKT_NUM_W-1:0] rx_head_pkt,
    input  logic [PKT_NUM_W-1:0] tx_pkt_num,
    input  logic [OFF_W-1:0]     off,
    output logic [RAM_AW-1:0]    word_addr,
    output logic                 lane
);
    logic [PKT_NUM_W-1:0] pkt;

    always_comb begin
        pkt       = rx_sel ? rx_head_pkt : tx_pkt_num;
        word_addr = {pkt, off[OFF_W-1:1]};
        lane      = off[0];
    end
endmodule

// File: rtl/pap_ctrl.sv
module pap_ctrl (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ptr_wr,
    input  logic        ptr_rd_bit,
    input  logic        dat_rd,
    input  logic        dat_wr,
    input  logic        dat_word,
    input  logic [15:0] dat_wdata,
    input  logic        rd_intent,
    input  logic        auto_inc,
    input  logic        lane,
    input  logic [15:0] ram_rdata,
    output logic        busy,
    output logic        adv,
    output logic        ram_en,
    output logic        ram_we,
    output logic [1:0]  ram_be,
    output logic [15:0] ram_wdata,
    output logic [15:0] dat_rdata
);
    import pap_pkg::*;

    pap_state_e state, state_nx;
    logic [DATA_W-1:0] pf_q;
    logic acc;

    assign acc = (state == ST_IDLE) && !ptr_wr &&
                 (dat_wr || (dat_rd && rd_intent));
    assign adv = acc && auto_inc;

    always_comb begin
        state_nx = state;
        if (ptr_wr) begin
            state_nx = ptr_rd_bit ? ST_FETCH : ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:    state_nx = (acc && rd_intent) ? ST_FETCH : ST_IDLE;
                ST_FETCH:   state_nx = ST_CAPTURE;
                ST_CAPTURE: state_nx = ST_IDLE;
                default:    state_nx = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                    pf_q <= '0;
        else if (state == ST_CAPTURE)  pf_q <= ram_rdata;
    end

    always_comb begin
        ram_en    = 1'b0;
        ram_we    = 1'b0;
        ram_be    = 2'b00;
        ram_wdata = dat_word ? dat_wdata : {dat_wdata[7:0], dat_wdata[7:0]};
        busy      = (state != ST_IDLE);
        dat_rdata = dat_word ? pf_q : {8'h00, (lane ? pf_q[15:8] : pf_q[7:0])};
        unique case (state)
            ST_IDLE: begin
                if (acc && dat_wr) begin
                    ram_en = 1'b1;
                    ram_we = 1'b1;
                    ram_be = dat_word ? 2'b11 : (lane ? 2'b10 : 2'b01);
                end
            end
            ST_FETCH: begin
                ram_en = 1'b1;
                ram_be = 2'b11;
            end
            ST_CAPTURE: ;
            default: ;
        endcase
    end

    AST_FETCH_TO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH && !ptr_wr) |=> (state == ST_CAPTURE)); // R8
    AST_CAPTURE_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CAPTURE && !ptr_wr) |=> !busy); // R8
endmodule

// File: rtl/pkt_access_port.sv
module pkt_access_port #(
    parameter int PKT_NUM_W = 4,
    parameter int WIN_BYTES = 2048,
    localparam int OFF_W    = $clog2(WIN_BYTES),
    localparam int RAM_AW   = PKT_NUM_W + OFF_W - 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ptr_wr,
    input  logic [15:0]          ptr_wdata,
    input  logic                 dat_rd,
    input  logic                 dat_wr,
    input  logic                 dat_word,
    input  logic [15:0]          dat_wdata,
    output logic [15:0]          dat_rdata,
    output logic                 busy,
    input  logic [PKT_NUM_W-1:0] rx_head_pkt,
    input  logic [PKT_NUM_W-1:0] tx_pkt_num,
    output logic                 ram_en,
    output logic                 ram_we,
    output logic [1:0]           ram_be,
    output logic [RAM_AW-1:0]    ram_addr,
    output logic [15:0]          ram_wdata,
    input  logic [15:0]          ram_rdata
);
    import pap_pkg::*;

    logic [OFF_W-1:0] off;
    logic rd_intent, auto_inc, rx_sel, adv, lane;

    pap_pointer #(.OFF_W(OFF_W)) u_ptr (
        .clk(clk), .rst_n(rst_n), .ld(ptr_wr), .ld_val(ptr_wdata),
        .adv(adv), .adv_word(dat_word), .off(off),
        .rd_intent(rd_intent), .auto_inc(auto_inc), .rx_sel(rx_sel)
    );

    pap_addr #(.PKT_NUM_W(PKT_NUM_W), .OFF_W(OFF_W)) u_addr (
        .rx_sel(rx_sel), .rx_head_pkt(rx_head_pkt), .tx_pkt_num(tx_pkt_num),
        .off(off), .word_addr(ram_addr), .lane(lane)
    );

    pap_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .ptr_wr(ptr_wr),
        .ptr_rd_bit(ptr_wdata[PTR_RD_BIT]),
        .dat_rd(dat_rd), .dat_wr(dat_wr), .dat_word(dat_word),
        .dat_wdata(dat_wdata), .rd_intent(rd_intent), .auto_inc(auto_inc),
        .lane(lane), .ram_rdata(ram_rdata), .busy(busy), .adv(adv),
        .ram_en(ram_en), .ram_we(ram_we), .ram_be(ram_be),
        .ram_wdata(ram_wdata), .dat_rdata(dat_rdata)
    );

    AST_PTR_STARTS_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_wr && ptr_wdata[PTR_RD_BIT]) |=> (ram_en && !ram_we)); // R8
    AST_WRITE_HAS_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (ram_en && ram_be != 2'b00)); // R4
    AST_NOINTENT_READ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_rd && !dat_wr && !ptr_wr && !rd_intent) |=> $stable(off)); // R10
    AST_BUSY_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && dat_wr) |-> !ram_we); // R12
endmodule

// File: tb/tb_pkt_access_port.sv
module tb_pkt_access_port;
    localparam int CLK_PERIOD = 10;
    localparam int PNW = 2;
    localparam int AW  = PNW + 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ptr_wr = 1'b0, dat_rd = 1'b0, dat_wr = 1'b0, dat_word = 1'b0;
    logic [15:0] ptr_wdata = '0, dat_wdata = '0;
    logic [15:0] dat_rdata, ram_wdata;
    logic [15:0] ram_rdata = '0;
    logic busy, ram_en, ram_we;
    logic [1:0] ram_be;
    logic [AW-1:0] ram_addr;
    logic [PNW-1:0] rx_head_pkt = 2'd2;
    logic [PNW-1:0] tx_pkt_num  = 2'd1;

    int checks = 0;
    int errors = 0;
    logic [15:0] mem [0:(1<<AW)-1];

    localparam logic [15:0] RD  = 16'h2000;
    localparam logic [15:0] INC = 16'h4000;
    localparam logic [15:0] RXS = 16'h8000;

    pkt_access_port #(.PKT_NUM_W(PNW)) dut (
        .clk(clk), .rst_n(rst_n), .ptr_wr(ptr_wr), .ptr_wdata(ptr_wdata),
        .dat_rd(dat_rd), .dat_wr(dat_wr), .dat_word(dat_word),
        .dat_wdata(dat_wdata), .dat_rdata(dat_rdata), .busy(busy),
        .rx_head_pkt(rx_head_pkt), .tx_pkt_num(tx_pkt_num),
        .ram_en(ram_en), .ram_we(ram_we), .ram_be(ram_be),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (ram_en) begin
            if (ram_we) begin
                if (ram_be[0]) mem[ram_addr][7:0]  <= ram_wdata[7:0];
                if (ram_be[1]) mem[ram_addr][15:8] <= ram_wdata[15:8];
            end else begin
                ram_rdata <= mem[ram_addr];
            end
        end
    end

    function automatic logic [15:0] pat(int a);
        return 16'(a) * 16'd7 + 16'h1234;
    endfunction

    function automatic int wa(int pkt, int off);
        return pkt * 1024 + off / 2;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic ptr_write(logic [15:0] v);
        @(negedge clk);
        ptr_wr = 1'b1; ptr_wdata = v;
        @(negedge clk);
        ptr_wr = 1'b0;
    endtask

    task automatic wait_idle(output int cyc);
        cyc = 0;
        while (busy) begin
            cyc++;
            @(negedge clk);
        end
    endtask

    task automatic rd(logic word, output logic [15:0] v);
        dat_rd = 1'b1; dat_word = word;
        #1 v = dat_rdata;
        @(negedge clk);
        dat_rd = 1'b0;
    endtask

    task automatic wr(logic word, logic [15:0] d, output logic [AW-1:0] a,
                      output logic [1:0] be, output logic [15:0] wd, output logic we);
        dat_wr = 1'b1; dat_word = word; dat_wdata = d;
        #1 a = ram_addr; be = ram_be; wd = ram_wdata; we = ram_we;
        @(negedge clk);
        dat_wr = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 busy", 32'(busy), 0);
        chk("R1 rdata", 32'(dat_rdata), 0);
        chk("R1 ram_en", 32'(ram_en), 0);
    endtask

    task automatic t_prefetch();
        int c; logic [15:0] v;
        ptr_write(RXS | RD | 16'h0010);
        wait_idle(c);
        chk("R8 busy cycles", c, 2);
        rd(1'b1, v);
        chk("R3 R9 rx word", v, pat(wa(2, 16'h10)));
        wait_idle(c);
        chk("R7 no inc no refetch shift", c, 2);
        rd(1'b1, v);
        chk("R7 same word again", v, pat(wa(2, 16'h10)));
        wait_idle(c);
    endtask

    task automatic t_byte_inc();
        int c; logic [15:0] v;
        ptr_write(RD | INC | 16'h0021);
        wait_idle(c);
        rd(1'b0, v);
        chk("R9 byte lane1", v, {8'h00, pat(wa(1, 16'h20))[15:8]});
        wait_idle(c);
        rd(1'b0, v);
        chk("R6 byte step to 0x22 lane0", v, {8'h00, pat(wa(1, 16'h22))[7:0]});
        wait_idle(c);
        rd(1'b1, v);
        chk("R5 word at odd aligns down", v, pat(wa(1, 16'h22)));
        wait_idle(c);
        rd(1'b1, v);
        chk("R6 word step to 0x24", v, pat(wa(1, 16'h24)));
        wait_idle(c);
    endtask

    task automatic t_wrap();
        int c; logic [15:0] v;
        ptr_write(RD | INC | 16'h07FE);
        wait_idle(c);
        rd(1'b1, v);
        chk("R6 last word", v, pat(wa(1, 16'h7FE)));
        wait_idle(c);
        rd(1'b1, v);
        chk("R6 wrap to 0", v, pat(wa(1, 0)));
        wait_idle(c);
    endtask

    task automatic t_writes();
        int c; logic [15:0] v, wd; logic [AW-1:0] a; logic [1:0] be; logic we;
        ptr_write(INC | 16'h0040);
        wr(1'b0, 16'h0011, a, be, wd, we);
        chk("R3 write addr", 32'(a), wa(1, 16'h40));
        chk("R4 lane0 be", 32'(be), 2'b01);
        chk("R4 lane0 data", 32'(wd[7:0]), 8'h11);
        wr(1'b0, 16'h0022, a, be, wd, we);
        chk("R4 lane1 be", 32'(be), 2'b10);
        chk("R4 lane1 data", 32'(wd[15:8]), 8'h22);
        wr(1'b1, 16'hBEEF, a, be, wd, we);
        chk("R5 word be", 32'(be), 2'b11);
        chk("R6 word write addr", 32'(a), wa(1, 16'h42));
        ptr_write(RD | 16'h0040);
        wait_idle(c);
        rd(1'b1, v);
        chk("R4 merged bytes", v, 16'h2211);
        wait_idle(c);
        ptr_write(RD | 16'h0042);
        wait_idle(c);
        rd(1'b1, v);
        chk("R5 word readback", v, 16'hBEEF);
        wait_idle(c);
    endtask

    task automatic t_no_intent();
        int c; logic [15:0] v, wd; logic [AW-1:0] a; logic [1:0] be; logic we;
        ptr_write(RD | 16'h0050);
        wait_idle(c);
        ptr_write(INC | 16'h0060);
        chk("R10 no fetch without intent", 32'(busy), 0);
        rd(1'b1, v);
        chk("R10 returns last fetched", v, pat(wa(1, 16'h50)));
        wr(1'b1, 16'h1357, a, be, wd, we);
        chk("R10 read did not advance", 32'(a), wa(1, 16'h60));
    endtask

    task automatic t_busy_ignore();
        int c; logic [15:0] v, wd; logic [AW-1:0] a; logic [1:0] be; logic we;
        ptr_write(RD | INC | 16'h0070);
        wr(1'b1, 16'hDEAD, a, be, wd, we);
        chk("R12 no write while busy", 32'(we), 0);
        wait_idle(c);
        rd(1'b1, v);
        chk("R12 memory and offset untouched", v, pat(wa(1, 16'h70)));
        wait_idle(c);
    endtask

    task automatic t_refetch_write();
        int c; logic [15:0] v, wd; logic [AW-1:0] a; logic [1:0] be; logic we;
        ptr_write(RD | INC | 16'h0080);
        wait_idle(c);
        wr(1'b1, 16'hCAFE, a, be, wd, we);
        wait_idle(c);
        chk("R11 write refetches", c, 2);
        rd(1'b1, v);
        chk("R11 next word after write", v, pat(wa(1, 16'h82)));
        wait_idle(c);
        ptr_write(RD | 16'h0080);
        wait_idle(c);
        rd(1'b1, v);
        chk("R11 written word", v, 16'hCAFE);
    endtask

    task automatic t_collide();
        int c; logic [15:0] v;
        @(negedge clk);
        ptr_wr = 1'b1; ptr_wdata = RD | 16'h0090; dat_wr = 1'b1; dat_word = 1'b1;
        dat_wdata = 16'h0BAD;
        @(negedge clk);
        ptr_wr = 1'b0; dat_wr = 1'b0;
        wait_idle(c);
        rd(1'b1, v);
        chk("R2 pointer write wins", v, pat(wa(1, 16'h90)));
        wait_idle(c);
    endtask

    initial begin
        for (int i = 0; i < (1 << AW); i++) mem[i] = pat(i);
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_prefetch();
        t_byte_inc();
        t_wrap();
        t_writes();
        t_no_intent();
        t_busy_ignore();
        t_refetch_write();
        t_collide();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule